// File: doc/BRIEF.md
# Return-Address Stack and Return Controller

This block keeps the return addresses of a small microcontroller in a fixed-depth hardware stack and restores the program counter when a return executes. Commands arrive on one valid/ready channel. Each command is one of five operations:

- a subroutine call, which pushes an address;
- an interrupt entry, which pushes an address and masks interrupts;
- a plain return;
- a return that also loads an immediate byte into the accumulator;
- a return from interrupt, which re-arms the master interrupt enable.

A return from interrupt may find another interrupt already waiting. In that case the block does not go back to the interrupted code. It puts the restored address back on the stack, sends the program counter to the supplied vector, and leaves interrupts masked. The caller's address therefore stays saved beneath the new service routine.

Back-pressure rules: `cmd_ready` is low during reset and stays high from the first clock edge after reset is released. A command is taken on any rising edge where `cmd_valid` and `cmd_ready` are both high. The program-counter and accumulator outputs are single-cycle valid pulses with no ready signal, because the fetch path cannot stall a redirect. Stack misuse does not corrupt anything: a push into a full stack, or a return from an empty one, is dropped and raises a sticky error flag. Return operations never change any status flag other than the interrupt enable.

Top module: `rtc_ret_ctrl`

## Requirements
- R1: While reset is asserted, and at its release, `cmd_ready`, `pc_valid`, `acc_valid`, `gie` and `stk_err` are 0 and `stk_level` is 0. `cmd_ready` becomes 1 one clock after reset is released.
- R2: A call (op code 0) taken while `stk_level` is below DEPTH pushes `cmd_addr` and raises `stk_level` by one. It produces no `pc_valid` or `acc_valid` pulse and leaves `gie` unchanged.
- R3: A plain return (op code 2) taken on a non-empty stack lowers `stk_level` by one. In the next cycle `pc_valid` is 1 and `pc_addr` equals the most recently pushed address still on the stack. `acc_valid` stays 0 and `gie` is unchanged.
- R4: A return with data (op code 3) behaves as R3. In the same cycle as the `pc_valid` pulse it also pulses `acc_valid` with `acc_data` equal to the `cmd_imm` taken with the command.
- R5: A return from interrupt (op code 4) taken on a non-empty stack while `irq_pend` is 0 restores `pc_addr` as in R3 and sets `gie` to 1.
- R6: A return from interrupt taken on a non-empty stack while `irq_pend` is 1 leaves `stk_level` unchanged and keeps the restored address on top of the stack. It pulses `pc_valid` with `pc_addr` equal to `irq_vec`, and `gie` is 0 afterwards.
- R7: An interrupt entry (op code 1) taken while `stk_level` is below DEPTH pushes `cmd_addr` as in R2 and sets `gie` to 0.
- R8: A call or interrupt entry taken with `stk_level` equal to DEPTH sets `stk_err`. It leaves `stk_level`, the stored addresses and `gie` unchanged and produces no pulse. `stk_err` then stays 1 until reset.
- R9: Any return taken with `stk_level` 0 sets `stk_err`. It produces no `pc_valid` or `acc_valid` pulse and leaves `gie` unchanged.
- R10: A cycle without a taken command, or a taken command with a reserved op code (5, 6 or 7), changes no output and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command channel can accept |
| cmd_op | input | 3 | 0 call, 1 interrupt entry, 2 return, 3 return with data, 4 return from interrupt |
| cmd_addr | input | AW | Return address to push on call or interrupt entry |
| cmd_imm | input | DW | Immediate byte for return with data |
| irq_pend | input | 1 | An interrupt is waiting |
| irq_vec | input | AW | Service routine address used when a waiting interrupt is taken |
| pc_valid | output | 1 | One-cycle program-counter load pulse |
| pc_addr | output | AW | New program counter value |
| acc_valid | output | 1 | One-cycle accumulator load pulse |
| acc_data | output | DW | Value to load into the accumulator |
| gie | output | 1 | Master interrupt enable |
| stk_err | output | 1 | Sticky overflow or underflow indication |
| stk_level | output | $clog2(DEPTH+1) | Number of addresses held |

## Verification
A return from interrupt that meets a waiting interrupt must pop and push the stack in one cycle. The program-counter source also switches from the stack top to the vector in that cycle. A return with data must raise the accumulator pulse in the same cycle as the program-counter pulse. The sweep uses a four-entry configuration and walks the stack between empty and full with a pseudo-random mix of every op code, `irq_pend` value and valid gap. This puts the combined pop and push on a full stack, where a wrong level update would falsely report overflow. Each outcome is judged against an arithmetic stack model. Later plain returns read back the re-pushed address, which shows the replaced entry was written to the right slot.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    OP_CALL = 3'd0,
    OP_IENT = 3'd1,
    OP_RET  = 3'd2,
    OP_RETD = 3'd3,
    OP_RETI = 3'd4
  } rtc_op_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic wsel_top;
    logic pc_vec;
    logic pc_ld;
    logic acc_ld;
    logic gie_set;
    logic gie_clr;
    logic err_set;
  } rtc_ctl_t;

endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  logic       take,
  input  logic [2:0] op,
  input  logic       full,
  input  logic       empty,
  input  logic       irq_pend,
  output rtc_ctl_t   ctl
);

  logic is_push_op;
  logic is_pop_op;

  assign is_push_op = (op == OP_CALL) || (op == OP_IENT);
  assign is_pop_op  = (op == OP_RET) || (op == OP_RETD) || (op == OP_RETI);

  always_comb begin
    ctl = '0;
    if (take && is_push_op) begin
      if (full) begin
        ctl.err_set = 1'b1;
      end else begin
        ctl.push    = 1'b1;
        ctl.gie_clr = (op == OP_IENT);
      end
    end else if (take && is_pop_op) begin
      if (empty) begin
        ctl.err_set = 1'b1;
      end else begin
        ctl.pop    = 1'b1;
        ctl.pc_ld  = 1'b1;
        ctl.acc_ld = (op == OP_RETD);
        if (op == OP_RETI) begin
          if (irq_pend) begin
            // keep the interrupted address saved and enter the waiting routine
            ctl.push     = 1'b1;
            ctl.wsel_top = 1'b1;
            ctl.pc_vec   = 1'b1;
            ctl.gie_clr  = 1'b1;
          end else begin
            ctl.gie_set = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_lifo.sv
module rtc_lifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [AW-1:0]                wdata,
  output logic [AW-1:0]                top,
  output logic [$clog2(DEPTH+1)-1:0]   lvl,
  output logic                         full,
  output logic                         empty
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [LW-1:0] lvl_q;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] mem [DEPTH];

  assign top_idx = IW'(lvl_q - LW'(1));
  // a simultaneous pop and push overwrites the current top in place
  assign wr_idx  = pop ? top_idx : IW'(lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (wr_idx == IW'(i))) mem[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign top   = mem[top_idx];
  assign lvl   = lvl_q;
  assign full  = (lvl_q == LVL_MAX);
  assign empty = (lvl_q == '0);

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic gie_set,
  input  logic gie_clr,
  input  logic err_set,
  output logic gie,
  output logic err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      err <= 1'b0;
    end else begin
      if (gie_clr)      gie <= 1'b0;
      else if (gie_set) gie <= 1'b1;
      if (err_set)      err <= 1'b1;
    end
  end

endmodule

// File: rtl/rtc_ret_ctrl.sv
module rtc_ret_ctrl
  import rtc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_op,
  input  logic [AW-1:0]              cmd_addr,
  input  logic [DW-1:0]              cmd_imm,
  input  logic                       irq_pend,
  input  logic [AW-1:0]              irq_vec,
  output logic                       pc_valid,
  output logic [AW-1:0]              pc_addr,
  output logic                       acc_valid,
  output logic [DW-1:0]              acc_data,
  output logic                       gie,
  output logic                       stk_err,
  output logic [$clog2(DEPTH+1)-1:0] stk_level
);

  logic          rdy_q;
  logic          take;
  rtc_ctl_t      ctl;
  logic          full;
  logic          empty;
  logic [AW-1:0] top;
  logic [AW-1:0] wdata;
  logic          pc_vld_q;
  logic [AW-1:0] pc_q;
  logic          acc_vld_q;
  logic [DW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign take = cmd_valid && rdy_q;

  rtc_decode u_dec (
    .take     (take),
    .op       (cmd_op),
    .full     (full),
    .empty    (empty),
    .irq_pend (irq_pend),
    .ctl      (ctl)
  );

  assign wdata = ctl.wsel_top ? top : cmd_addr;

  rtc_lifo #(.DEPTH(DEPTH), .AW(AW)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ctl.push),
    .pop   (ctl.pop),
    .wdata (wdata),
    .top   (top),
    .lvl   (stk_level),
    .full  (full),
    .empty (empty)
  );

  rtc_flags u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_set (ctl.gie_set),
    .gie_clr (ctl.gie_clr),
    .err_set (ctl.err_set),
    .gie     (gie),
    .err     (stk_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_vld_q  <= 1'b0;
      pc_q      <= '0;
      acc_vld_q <= 1'b0;
      acc_q     <= '0;
    end else begin
      pc_vld_q  <= ctl.pc_ld;
      acc_vld_q <= ctl.acc_ld;
      if (ctl.pc_ld)  pc_q  <= ctl.pc_vec ? irq_vec : top;
      if (ctl.acc_ld) acc_q <= cmd_imm;
    end
  end

  assign cmd_ready = rdy_q;
  assign pc_valid  = pc_vld_q;
  assign pc_addr   = pc_q;
  assign acc_valid = acc_vld_q;
  assign acc_data  = acc_q;

endmodule

// File: rtl/rtc_ret_ctrl_chk.sv
module rtc_ret_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [2:0]                 cmd_op,
  input logic [AW-1:0]              cmd_addr,
  input logic [DW-1:0]              cmd_imm,
  input logic                       irq_pend,
  input logic [AW-1:0]              irq_vec,
  input logic                       pc_valid,
  input logic [AW-1:0]              pc_addr,
  input logic                       acc_valid,
  input logic [DW-1:0]              acc_data,
  input logic                       gie,
  input logic                       stk_err,
  input logic [$clog2(DEPTH+1)-1:0] stk_level
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic tk;
  logic is_push;
  logic is_pop;
  assign tk      = cmd_valid && cmd_ready;
  assign is_push = tk && (cmd_op == 3'd0 || cmd_op == 3'd1);
  assign is_pop  = tk && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4);

  a_r2_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd0 && stk_level != LVL_MAX) |=>
      (stk_level == $past(stk_level) + LW'(1)) && !pc_valid && !acc_valid);

  a_r3_call_then_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd2 && $past(tk && cmd_op == 3'd0 && stk_level != LVL_MAX)) |=>
      pc_valid && (pc_addr == $past(cmd_addr, 2)));

  a_r3_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd2 && stk_level != '0) |=>
      pc_valid && !acc_valid && (stk_level == $past(stk_level) - LW'(1)));

  a_r4_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd3 && stk_level != '0) |=>
      pc_valid && acc_valid && (acc_data == $past(cmd_imm)));

  a_r4_acc_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> pc_valid);

  a_r5_reti_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd4 && stk_level != '0 && !irq_pend) |=> pc_valid && gie);

  a_r6_reti_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd4 && stk_level != '0 && irq_pend) |=>
      pc_valid && (pc_addr == $past(irq_vec)) && !gie &&
      (stk_level == $past(stk_level)));

  a_r7_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cmd_op == 3'd1 && stk_level != LVL_MAX) |=> !gie);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_push && stk_level == LVL_MAX) |=> stk_err && (stk_level == LVL_MAX) && $stable(gie));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pop && stk_level == '0) |=> stk_err && !pc_valid && !acc_valid && $stable(gie));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_push && !is_pop) |=> !pc_valid && !acc_valid && $stable(stk_level) && $stable(gie));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_level <= LVL_MAX);

endmodule

bind rtc_ret_ctrl rtc_ret_ctrl_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .cmd_imm   (cmd_imm),
  .irq_pend  (irq_pend),
  .irq_vec   (irq_vec),
  .pc_valid  (pc_valid),
  .pc_addr   (pc_addr),
  .acc_valid (acc_valid),
  .acc_data  (acc_data),
  .gie       (gie),
  .stk_err   (stk_err),
  .stk_level (stk_level)
);

// File: tb/sim_rtc_ret_ctrl.sv
module sim_rtc_ret_ctrl;

  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_imm = '0;
  logic          irq_pend = 1'b0;
  logic [AW-1:0] irq_vec = '0;
  logic          pc_valid;
  logic [AW-1:0] pc_addr;
  logic          acc_valid;
  logic [DW-1:0] acc_data;
  logic          gie;
  logic          stk_err;
  logic [LW-1:0] stk_level;

  always #5 clk = ~clk;

  rtc_ret_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_imm(cmd_imm),
    .irq_pend(irq_pend), .irq_vec(irq_vec), .pc_valid(pc_valid),
    .pc_addr(pc_addr), .acc_valid(acc_valid), .acc_data(acc_data),
    .gie(gie), .stk_err(stk_err), .stk_level(stk_level)
  );

  int vectors = 0;
  int errors  = 0;
  logic done = 1'b0;

  logic [AW-1:0] m_stk [DEPTH];
  int   m_lvl;
  logic m_gie;
  logic m_err;
  logic [31:0] lf = 32'h1ACE_5EED;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    @(negedge clk);
    vectors++;
    chk("R1", "ready in reset", int'(cmd_ready), 0);
    chk("R1", "level in reset", int'(stk_level), 0);
    chk("R1", "gie in reset", int'(gie), 0);
    chk("R1", "err in reset", int'(stk_err), 0);
    chk("R1", "pc_valid in reset", int'(pc_valid), 0);
    chk("R1", "acc_valid in reset", int'(acc_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(cmd_ready), 1);
    m_lvl = 0;
    m_gie = 1'b0;
    m_err = 1'b0;
  endtask

  task automatic one_vector();
    string tag;
    logic e_pcv, e_accv;
    logic [AW-1:0] e_pc, t;
    logic [DW-1:0] e_acc;
    for (int k = 0; k < 3; k++) lf = step(lf);
    cmd_valid = (lf[3:0] != 4'd0);
    cmd_op    = lf[6:4];
    irq_pend  = lf[7];
    cmd_addr  = lf[15:8];
    cmd_imm   = lf[23:16];
    irq_vec   = lf[31:24];
    e_pcv = 1'b0; e_accv = 1'b0; e_pc = '0; e_acc = '0; tag = "R10";
    if (cmd_valid) begin
      case (cmd_op)
        3'd0, 3'd1: begin
          if (m_lvl == DEPTH) begin
            m_err = 1'b1; tag = "R8";
          end else begin
            m_stk[m_lvl] = cmd_addr;
            m_lvl++;
            if (cmd_op == 3'd1) begin m_gie = 1'b0; tag = "R7"; end
            else tag = "R2";
          end
        end
        3'd2, 3'd3, 3'd4: begin
          if (m_lvl == 0) begin
            m_err = 1'b1; tag = "R9";
          end else begin
            m_lvl--;
            t = m_stk[m_lvl];
            e_pcv = 1'b1; e_pc = t;
            tag = "R3";
            if (cmd_op == 3'd3) begin e_accv = 1'b1; e_acc = cmd_imm; tag = "R4"; end
            if (cmd_op == 3'd4) begin
              if (irq_pend) begin
                m_stk[m_lvl] = t; m_lvl++;
                e_pc = irq_vec; m_gie = 1'b0; tag = "R6";
              end else begin
                m_gie = 1'b1; tag = "R5";
              end
            end
          end
        end
        default: tag = "R10";
      endcase
    end
    @(negedge clk);
    vectors++;
    chk(tag, "pc_valid", int'(pc_valid), int'(e_pcv));
    if (e_pcv) chk(tag, "pc_addr", int'(pc_addr), int'(e_pc));
    chk(tag, "acc_valid", int'(acc_valid), int'(e_accv));
    if (e_accv) chk(tag, "acc_data", int'(acc_data), int'(e_acc));
    chk(tag, "gie", int'(gie), int'(m_gie));
    chk(tag, "stk_err", int'(stk_err), int'(m_err));
    chk(tag, "stk_level", int'(stk_level), m_lvl);
  endtask

  initial begin
    for (int c = 0; c < 40; c++) begin
      do_reset();
      for (int v = 0; v < 64; v++) one_vector();
    end
    cmd_valid = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule